// File: doc/BRIEF.md
# Dual-Mode Programmable Feedback Divider

This block is the feedback divider of a tuner frequency synthesizer. Each rising edge of `clk` stands for one edge of the selected oscillator input. The block counts those edges and raises `div_pulse` for one cycle each time a full division period has elapsed. That pulse is the feedback edge sent to the phase detector. A 16-bit ratio word and two configuration bits select one of three counting arrangements.

The first arrangement is the high-band path. A fixed halving stage runs ahead of the programmable counter, so the word holds half of the total ratio. The second is the low-band path with swallow counting. A dual-modulus prescaler of modulus 16/17 runs ahead of a main counter, and a 4-bit swallow counter sets how many prescaler cycles use the larger modulus. The prescaler's modulus-select line is brought out as `mod_hi`. The third is the low-band direct path. Here the prescaler is bypassed and only the upper twelve bits of the word count.

The word and both mode bits may be rewritten at any time. The counters take the new values only when the current period ends, so no period is ever cut short. A ratio below the smallest value the selected path can divide by is raised to that minimum.

Top module: `pll_div_top`

## Requirements
- R1: While `rst_n` is low, `div_pulse` and `mod_hi` are both low. Asserting `rst_n` in the middle of a period forces both outputs low at once.
- R2: With `band_am`=0, the distance between consecutive `div_pulse` assertions is 2·`div_word` cycles.
- R3: With `band_am`=1 and `swallow_en`=1, let M be `div_word[15:4]` and A be `div_word[3:0]`. The pulse period is M·16 + A cycles.
- R4: With `band_am`=1 and `swallow_en`=0, the pulse period is `div_word[15:4]` cycles. Bits `div_word[3:0]` have no effect on the period.
- R5: In swallow mode, `mod_hi` (1 = divide-by-17 selected) is high for exactly A·17 cycles of every period. In both other modes it stays low.
- R6: A new word or mode takes effect only at the end of the period in progress. That period completes with the ratio and mode it started with.
- R7: `div_pulse` is high for exactly one cycle per period. It is never high in two consecutive cycles.
- R8: Out-of-range ratios are clamped to a minimum. In the halved path a word below 2 acts as 2, giving a period of 4. In the direct path an upper field below 2 acts as 2. In swallow mode a word below 256 acts as 256, giving a period of 256 with `mod_hi` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | One rising edge per edge of the selected oscillator input |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| div_word | input | 16 | Division ratio word |
| band_am | input | 1 | 0 selects the halved high-band path, 1 selects the low-band input |
| swallow_en | input | 1 | With `band_am`=1, 1 enables prescaler and swallow counting |
| div_pulse | output | 1 | One-cycle pulse at the end of each division period |
| mod_hi | output | 1 | Prescaler modulus select: 1 = divide by 17, 0 = divide by 16 |

## Verification
The assertions assume that `div_word`, `band_am` and `swallow_en` are synchronous to `clk` and stable around the edge at which a period ends. They also assume that every clamped ratio gives a period of at least two cycles, which keeps the prescaler's spacing and the single-cycle pulse rule meaningful. The stimulus changes the configuration only on falling edges, directly after a pulse has been seen, or at a deliberate point in the middle of a period. It then measures whole periods only after the change has had a full boundary to take effect. Every clamp value and every swallow count from 0 to 15 is swept, with both small and large main values.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;
  typedef enum logic [1:0] {
    MODE_HALF   = 2'd0,
    MODE_SWAL   = 2'd1,
    MODE_DIRECT = 2'd2
  } div_mode_e;
endpackage

// File: rtl/pll_div_cfg.sv
module pll_div_cfg
  import pll_div_pkg::*;
#(
  parameter int W        = 16,
  parameter int SWB      = 4,
  parameter int MIN_MAIN = 2
) (
  input  logic [W-1:0]   word,
  input  logic           band_am,
  input  logic           swallow_en,
  output div_mode_e      mode_ld,
  output logic [W-1:0]   main_ld,
  output logic [SWB-1:0] swal_ld
);
  localparam int HW = W - SWB;
  localparam logic [W-1:0] MIN_L    = W'(MIN_MAIN);
  localparam logic [W-1:0] MIN_SW_L = W'(2 ** SWB);

  logic [W-1:0] upper;

  assign upper = {{SWB{1'b0}}, word[W-1:SWB]};

  always_comb begin
    if (!band_am)       mode_ld = MODE_HALF;
    else if (swallow_en) mode_ld = MODE_SWAL;
    else                 mode_ld = MODE_DIRECT;
  end

  always_comb begin
    main_ld = MIN_L;
    swal_ld = '0;
    unique case (mode_ld)
      MODE_HALF: begin
        main_ld = (word < MIN_L) ? MIN_L : word;
      end
      MODE_SWAL: begin
        if (upper < MIN_SW_L) begin
          main_ld = MIN_SW_L;
          swal_ld = '0;
        end else begin
          main_ld = upper;
          swal_ld = word[SWB-1:0];
        end
      end
      default: begin
        main_ld = (upper < MIN_L) ? MIN_L : upper;
      end
    endcase
  end

  logic unused_hw;
  assign unused_hw = (HW > 0);
endmodule

// File: rtl/pll_div_presc.sv
module pll_div_presc
  import pll_div_pkg::*;
#(
  parameter int SWB = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  div_mode_e mode_nx,
  input  logic      mod_nx,
  output logic      tick
);
  localparam int P  = 2 ** SWB;
  localparam int CW = SWB + 1;

  logic [CW-1:0] pre_q, pre_d;

  assign tick = (pre_q == '0);

  always_comb begin
    if (tick) begin
      unique case (mode_nx)
        MODE_HALF: pre_d = CW'(1);
        MODE_SWAL: pre_d = mod_nx ? CW'(P) : CW'(P - 1);
        default:   pre_d = '0;
      endcase
    end else begin
      pre_d = pre_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/pll_div_count.sv
module pll_div_count
  import pll_div_pkg::*;
#(
  parameter int W   = 16,
  parameter int SWB = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  div_mode_e      mode_ld,
  input  logic [W-1:0]   main_ld,
  input  logic [SWB-1:0] swal_ld,
  output logic           tc,
  output div_mode_e      mode_q,
  output div_mode_e      mode_nx,
  output logic           mod_nx,
  output logic           mod_hi,
  output logic           pulse
);
  logic [W-1:0]   main_q, main_d;
  logic [SWB-1:0] swal_q, swal_d;
  div_mode_e      mode_d;
  logic           armed_q, armed_d;
  logic           pulse_q, pulse_d;
  logic           mod_q;
  logic           cnt_en;

  assign cnt_en = tick;
  assign tc     = tick && (main_q == W'(1));

  always_comb begin
    main_d = main_q;
    swal_d = swal_q;
    mode_d = mode_q;
    if (tc) begin
      main_d = main_ld;
      swal_d = swal_ld;
      mode_d = mode_ld;
    end else if (tick) begin
      main_d = main_q - W'(1);
      swal_d = (swal_q != '0) ? swal_q - SWB'(1) : swal_q;
    end
  end

  assign mode_nx = mode_d;
  assign mod_nx  = (mode_d == MODE_SWAL) && (swal_d != '0);
  assign armed_d = armed_q | tc;
  assign pulse_d = tc & armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q <= W'(1);
      swal_q <= '0;
      mode_q <= MODE_DIRECT;
    end else if (cnt_en) begin
      main_q <= main_d;
      swal_q <= swal_d;
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      pulse_q <= 1'b0;
      mod_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      pulse_q <= pulse_d;
      mod_q   <= mod_nx;
    end
  end

  assign mod_hi = mod_q;
  assign pulse  = pulse_q;
endmodule

// File: rtl/pll_div_top.sv
module pll_div_top
  import pll_div_pkg::*;
#(
  parameter int W        = 16,
  parameter int SWB      = 4,
  parameter int MIN_MAIN = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] div_word,
  input  logic         band_am,
  input  logic         swallow_en,
  output logic         div_pulse,
  output logic         mod_hi
);
  logic           rst_s1, rst_s2;
  logic           rst_sync_n;
  div_mode_e      mode_ld, mode_q, mode_nx;
  logic [W-1:0]   main_ld;
  logic [SWB-1:0] swal_ld;
  logic           tick, tc, mod_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end
  assign rst_sync_n = rst_s2;

  pll_div_cfg #(.W(W), .SWB(SWB), .MIN_MAIN(MIN_MAIN)) u_cfg (
    .word       (div_word),
    .band_am    (band_am),
    .swallow_en (swallow_en),
    .mode_ld    (mode_ld),
    .main_ld    (main_ld),
    .swal_ld    (swal_ld)
  );

  pll_div_presc #(.SWB(SWB)) u_presc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .mode_nx (mode_nx),
    .mod_nx  (mod_nx),
    .tick    (tick)
  );

  pll_div_count #(.W(W), .SWB(SWB)) u_count (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick    (tick),
    .mode_ld (mode_ld),
    .main_ld (main_ld),
    .swal_ld (swal_ld),
    .tc      (tc),
    .mode_q  (mode_q),
    .mode_nx (mode_nx),
    .mod_nx  (mod_nx),
    .mod_hi  (mod_hi),
    .pulse   (div_pulse)
  );
endmodule

// File: rtl/pll_div_chk.sv
module pll_div_chk
  import pll_div_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      div_pulse,
  input logic      mod_hi,
  input logic      tick,
  input logic      tc,
  input div_mode_e mode_q,
  input div_mode_e mode_nx
);
  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  p_pulse_at_tc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |-> $past(tc));

  p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tc |=> $stable(mode_q));

  p_mod_rise_at_tc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_hi) |-> $past(tc));

  p_mod_swal_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mod_hi |-> (mode_q == MODE_SWAL));

  p_half_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (mode_nx == MODE_HALF)) |=> !tick);
endmodule

bind pll_div_top pll_div_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .div_pulse (div_pulse),
  .mod_hi    (mod_hi),
  .tick      (tick),
  .tc        (tc),
  .mode_q    (mode_q),
  .mode_nx   (mode_nx)
);

// File: tb/sim_pll_div_top.sv
`timescale 1ns/1ps
module sim_pll_div_top;
  logic        clk;
  logic        rst_n;
  logic [15:0] div_word;
  logic        band_am;
  logic        swallow_en;
  logic        div_pulse;
  logic        mod_hi;

  int n_chk  = 0;
  int n_fail = 0;

  pll_div_top u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .div_word   (div_word),
    .band_am    (band_am),
    .swallow_en (swallow_en),
    .div_pulse  (div_pulse),
    .mod_hi     (mod_hi)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_period(input int w, input bit am, input bit sw);
    int v;
    if (!am) begin
      v = (w < 2) ? 2 : w;
      return 2 * v;
    end else if (sw) begin
      v = (w < 256) ? 256 : w;
      return (v >> 4) * 16 + (v & 15);
    end else begin
      v = w >> 4;
      if (v < 2) v = 2;
      return v;
    end
  endfunction

  function automatic int exp_mod(input int w, input bit am, input bit sw);
    if (am && sw && w >= 256) return (w & 15) * 17;
    return 0;
  endfunction

  task automatic wait_pulse(output int cyc, output int mh);
    cyc = 0;
    mh  = 0;
    do begin
      @(negedge clk);
      cyc++;
      if (mod_hi) mh++;
    end while (!div_pulse && cyc < 30000);
    if (!div_pulse) begin
      n_chk++;
      n_fail++;
      $display("FAIL R7: no pulse, actual %0d cycles expected fewer than 30000", cyc);
    end
  endtask

  task automatic run_cfg(input int w, input bit am, input bit sw, input string tag);
    int cyc, mh, ep;
    div_word   = 16'(w);
    band_am    = am;
    swallow_en = sw;
    wait_pulse(cyc, mh);
    wait_pulse(cyc, mh);
    ep = exp_period(w, am, sw);
    check(cyc == ep, tag, cyc, ep);
    check(mh == exp_mod(w, am, sw), "R5", mh, exp_mod(w, am, sw));
  endtask

  task automatic count_pulses(input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (div_pulse) hits++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual 190000 cycles expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cyc, mh, hits;
    rst_n      = 1'b0;
    div_word   = 16'd10;
    band_am    = 1'b0;
    swallow_en = 1'b0;
    repeat (5) begin
      @(negedge clk);
      check(!div_pulse && !mod_hi, "R1 reset", int'({div_pulse, mod_hi}), 0);
    end
    rst_n = 1'b1;
    wait_pulse(cyc, mh);

    // R2 halved path, with clamp values for R8
    foreach (fm_set[i]) run_cfg(fm_set[i], 1'b0, 1'b0, (fm_set[i] < 2) ? "R8 half" : "R2");

    // R4 direct path: low bits vary, only upper field counts
    for (int m = 0; m < 8; m++) begin
      run_cfg((m << 4) | ((m * 5 + 3) & 15), 1'b1, 1'b0, (m < 2) ? "R8 direct" : "R4");
    end
    run_cfg((40 << 4) | 4'hF, 1'b1, 1'b0, "R4");
    run_cfg((40 << 4) | 4'h0, 1'b1, 1'b0, "R4");

    // R3 swallow sweep over every swallow count
    for (int m = 16; m < 18; m++) begin
      for (int a = 0; a < 16; a++) run_cfg((m << 4) | a, 1'b1, 1'b1, "R3");
    end
    run_cfg(16'h1F4F, 1'b1, 1'b1, "R3");
    run_cfg(0,   1'b1, 1'b1, "R8 swallow");
    run_cfg(255, 1'b1, 1'b1, "R8 swallow");

    // R7 shortest periods: pulse count in a fixed window
    run_cfg(2 << 4, 1'b1, 1'b0, "R4");
    count_pulses(8, hits);
    check(hits == 4, "R7 direct min", hits, 4);
    run_cfg(2, 1'b0, 1'b0, "R2");
    count_pulses(16, hits);
    check(hits == 4, "R7 half min", hits, 4);

    // R6 mid-period rewrite does not truncate the running period
    run_cfg(100, 1'b0, 1'b0, "R2");
    repeat (50) @(negedge clk);
    div_word = 16'(48 << 4);
    band_am  = 1'b1;
    wait_pulse(cyc, mh);
    check(cyc + 50 == 200, "R6 old period", cyc + 50, 200);
    wait_pulse(cyc, mh);
    check(cyc == 48, "R6 new period", cyc, 48);

    // R1 reset in the middle of a swallow period
    run_cfg((16 << 4) | 15, 1'b1, 1'b1, "R3");
    repeat (3) @(negedge clk);
    check(mod_hi, "R5 early high", int'(mod_hi), 1);
    rst_n = 1'b0;
    #1;
    check(!div_pulse && !mod_hi, "R1 async", int'({div_pulse, mod_hi}), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  int fm_set[9] = '{0, 1, 2, 3, 5, 8, 17, 100, 500};
endmodule